// File: doc/BRIEF.md
# Per-Card SD Clock Generator

This block derives a separate card clock for each of up to four card slots from a single reference clock. Each slot picks one of four shared 8-bit divider values through a 2-bit source field. The slot's clock runs at the reference rate divided by twice that value, or at the full reference rate when the value is zero. Each slot also has a run enable and a low-power enable. In low-power mode the slot's clock stops while both the command engine and the data engine report that slot idle.

Divider, source and enable words are not used as soon as they are driven. They are captured into a staging copy only when the command unit raises an update request. Each slot then takes the staged values into use at a moment when its own clock is low. A busy flag stays high until every slot has loaded the new values, and a one-cycle acknowledge marks its fall. This keeps the card clocks free of shortened pulses across reprogramming. All control and status pins are plain levels or pulses; no data stream crosses the block, so there is no back-pressure.

Top module: `card_clk_gen`

## Requirements
- R1: `div_word` holds divider k in bits [8k+7:8k]. Slot n uses the divider whose index is `src_word[2n+1:2n]`.
- R2: A selected divider value N greater than 0 gives the slot a clock with a period of 2×N reference cycles.
- R3: A selected divider value of 0 gives the slot one rising edge per reference cycle, the reference clock passed through.
- R4: `gate_word` bit n (n = 0..3) enables slot n. While its applied enable is 0, the slot clock is held low.
- R5: `gate_word` bit 16+n enables low-power mode for slot n. In that mode the slot clock stops low while `cmd_idle[n]` and `dat_idle[n]` are both 1, and it runs again once either of them is 0.
- R6: Word inputs have no effect until `upd_req` is sampled high while `upd_busy` is 0. `upd_busy` is then 1 from the next cycle until every slot has loaded, and `upd_ack` pulses for one cycle in the cycle `upd_busy` falls.
- R7: An `upd_req` sampled while `upd_busy` is 1 is ignored. The words captured earlier are the ones applied.
- R8: A slot loads new settings only while its clock is low. A high phase already in progress completes at full width before any change.
- R9: After reset all slot clocks are low and all slots are disabled, with `upd_busy` and `upd_ack` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | 32 | Four packed divider values |
| src_word | input | 8 | Per-slot divider select fields |
| gate_word | input | 32 | Run enables [3:0], low-power enables [19:16] |
| cmd_idle | input | 4 | Command engine idle, per slot |
| dat_idle | input | 4 | Data engine idle, per slot |
| upd_req | input | 1 | Update request pulse from the command unit |
| upd_busy | output | 1 | Update captured and not yet applied to all slots |
| upd_ack | output | 1 | One-cycle pulse when the update completes |
| card_clk | output | 4 | Card clocks |

## Verification
The bench counts rising edges of every slot clock over fixed windows. It compares each count with the rate expected from the staged settings. A swapped source lookup or an off-by-one divider changes the count by far more than the allowed single edge. It drives new words without a request, and it re-requests while busy after starting the update in a long high phase. A design that applied words early, or accepted the second request, would show the wrong rate. Low-power gating is checked with only one idle input high, then both, then neither; a design that used OR instead of AND for the idle condition would stop the clock when it should run.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int CK_CARDS   = 4;
  localparam int CK_DIV_W   = 8;
  localparam int CK_LP_BASE = 16;
  localparam int CK_GATE_W  = 32;

  function automatic int src_width(input int cards);
    return (cards > 1) ? $clog2(cards) : 1;
  endfunction
endpackage

// File: rtl/card_clk_shadow.sv
module card_clk_shadow
  import card_clk_pkg::*;
#(
  parameter int N_CARDS = CK_CARDS,
  parameter int DIV_W   = CK_DIV_W,
  localparam int SRC_W  = src_width(N_CARDS),
  localparam int DWORD_W = N_CARDS * DIV_W,
  localparam int SWORD_W = N_CARDS * SRC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_req,
  input  logic [DWORD_W-1:0]   div_word,
  input  logic [SWORD_W-1:0]   src_word,
  input  logic [CK_GATE_W-1:0] gate_word,
  input  logic [N_CARDS-1:0]   phase_lo,
  output logic [DWORD_W-1:0]   act_div,
  output logic [N_CARDS-1:0]   act_en,
  output logic [N_CARDS-1:0]   act_lp,
  output logic [N_CARDS-1:0]   load,
  output logic                 upd_busy,
  output logic                 upd_ack
);
  logic [DWORD_W-1:0] stg_div;
  logic [N_CARDS-1:0] stg_en;
  logic [N_CARDS-1:0] stg_lp;
  logic [N_CARDS-1:0] pending;
  logic               accept;

  assign accept   = upd_req && (pending == '0);
  assign load     = pending & phase_lo;
  assign upd_busy = (pending != '0);

  generate
    for (genvar i = 0; i < N_CARDS; i++) begin : g_slot
      logic [SRC_W-1:0] sel;
      assign sel = src_word[i*SRC_W +: SRC_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_div[i*DIV_W +: DIV_W] <= '0;
          stg_en[i]                 <= 1'b0;
          stg_lp[i]                 <= 1'b0;
        end else if (accept) begin
          stg_div[i*DIV_W +: DIV_W] <= div_word[sel*DIV_W +: DIV_W];
          stg_en[i]                 <= gate_word[i];
          stg_lp[i]                 <= gate_word[CK_LP_BASE + i];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_div[i*DIV_W +: DIV_W] <= '0;
          act_en[i]                 <= 1'b0;
          act_lp[i]                 <= 1'b0;
        end else if (load[i]) begin
          act_div[i*DIV_W +: DIV_W] <= stg_div[i*DIV_W +: DIV_W];
          act_en[i]                 <= stg_en[i];
          act_lp[i]                 <= stg_lp[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      upd_ack <= 1'b0;
    end else begin
      if (accept) pending <= '1;
      else        pending <= pending & ~load;
      upd_ack <= (pending != '0) && ((pending & ~load) == '0);
    end
  end

  // R7: a request during an update leaves the staged words untouched
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_busy && upd_req) |=> ($stable(stg_div) && $stable(stg_en) && $stable(stg_lp)));

  // R6: acknowledge pulses exactly when busy falls
  assert_ack_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_busy) |-> upd_ack);

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ack |=> !upd_ack);

  // R6: applied settings change only through a load
  assert_apply_only_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_busy) |-> ($stable(act_div) && $stable(act_en) && $stable(act_lp)));
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_pkg::*;
#(
  parameter int DIV_W = CK_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] act_div,
  input  logic             act_en,
  input  logic             act_lp,
  input  logic             cmd_idle,
  input  logic             dat_idle,
  input  logic             load,
  output logic             phase_lo,
  output logic             card_clk
);
  logic [DIV_W-1:0] cnt;
  logic             div_q;
  logic             run;
  logic             bypass;
  logic             byp_n;
  logic             gate_n;

  assign run      = act_en && !(act_lp && cmd_idle && dat_idle);
  assign bypass   = (act_div == '0);
  assign phase_lo = !div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (load) begin
      cnt <= '0;
    end else if (!bypass && (run || div_q)) begin
      if (cnt == act_div - 1'b1) begin
        cnt   <= '0;
        div_q <= !div_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // pass-through gate and mode select change only while the reference is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_n  <= 1'b0;
      gate_n <= 1'b0;
    end else begin
      byp_n  <= bypass;
      gate_n <= bypass && run;
    end
  end

  assign card_clk = (clk & gate_n) | (div_q & !byp_n);

  // R8: new settings are never taken while the slot clock is high
  assert_load_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !div_q);

  // R4: a disabled slot has neither a divided nor a passed clock
  assert_off_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> (!div_q && !gate_n));

  // R5: a gated low-power slot never begins a new high phase
  assert_lp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lp && cmd_idle && dat_idle && !div_q && !load) |=> !div_q);

  // R2: the divided clock only moves while a divider is selected
  assert_bypass_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !div_q) |=> !div_q);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int N_CARDS = CK_CARDS,
  parameter int DIV_W   = CK_DIV_W,
  localparam int SRC_W  = src_width(N_CARDS),
  localparam int DWORD_W = N_CARDS * DIV_W,
  localparam int SWORD_W = N_CARDS * SRC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DWORD_W-1:0]   div_word,
  input  logic [SWORD_W-1:0]   src_word,
  input  logic [CK_GATE_W-1:0] gate_word,
  input  logic [N_CARDS-1:0]   cmd_idle,
  input  logic [N_CARDS-1:0]   dat_idle,
  input  logic                 upd_req,
  output logic                 upd_busy,
  output logic                 upd_ack,
  output logic [N_CARDS-1:0]   card_clk
);
  logic [DWORD_W-1:0] act_div;
  logic [N_CARDS-1:0] act_en;
  logic [N_CARDS-1:0] act_lp;
  logic [N_CARDS-1:0] load;
  logic [N_CARDS-1:0] phase_lo;

  card_clk_shadow #(.N_CARDS(N_CARDS), .DIV_W(DIV_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_req   (upd_req),
    .div_word  (div_word),
    .src_word  (src_word),
    .gate_word (gate_word),
    .phase_lo  (phase_lo),
    .act_div   (act_div),
    .act_en    (act_en),
    .act_lp    (act_lp),
    .load      (load),
    .upd_busy  (upd_busy),
    .upd_ack   (upd_ack)
  );

  generate
    for (genvar i = 0; i < N_CARDS; i++) begin : g_card
      card_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_div  (act_div[i*DIV_W +: DIV_W]),
        .act_en   (act_en[i]),
        .act_lp   (act_lp[i]),
        .cmd_idle (cmd_idle[i]),
        .dat_idle (dat_idle[i]),
        .load     (load[i]),
        .phase_lo (phase_lo[i]),
        .card_clk (card_clk[i])
      );
    end
  endgenerate

  // R9: nothing is pending once reset has been released and no request came
  assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_busy && !upd_req) |=> !upd_busy);
endmodule

// File: tb/test_card_clk_gen.sv
`timescale 1ns/1ps
module test_card_clk_gen;
  localparam int NC = 4;
  localparam int W  = 2400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] div_word = '0;
  logic [7:0]  src_word = '0;
  logic [31:0] gate_word = '0;
  logic [3:0]  cmd_idle = '0;
  logic [3:0]  dat_idle = '0;
  logic        upd_req = 1'b0;
  logic        upd_busy, upd_ack;
  logic [3:0]  card_clk;

  int checks = 0;
  int errors = 0;
  int ecount [NC];
  int got [NC];

  always #2.5 clk = !clk;

  card_clk_gen i_card_clk_gen (
    .clk(clk), .rst_n(rst_n), .div_word(div_word), .src_word(src_word),
    .gate_word(gate_word), .cmd_idle(cmd_idle), .dat_idle(dat_idle),
    .upd_req(upd_req), .upd_busy(upd_busy), .upd_ack(upd_ack), .card_clk(card_clk)
  );

  for (genvar g = 0; g < NC; g++) begin : g_cnt
    initial ecount[g] = 0;
    always @(posedge card_clk[g]) ecount[g] = ecount[g] + 1;
  end

  function automatic int exp_edges(input int n, input bit run);
    if (!run) return 0;
    if (n == 0) return W;
    return W / (2 * n);
  endfunction

  function automatic int pick_div(input logic [31:0] dw, input logic [7:0] sw, input int card);
    int k;
    k = sw[2*card +: 2];
    return dw[8*k +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure();
    int base [NC];
    for (int i = 0; i < NC; i++) base[i] = ecount[i];
    repeat (W) @(posedge clk);
    #1;
    for (int i = 0; i < NC; i++) got[i] = ecount[i] - base[i];
  endtask

  task automatic request(output int lat);
    @(negedge clk);
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    lat = 1;
    while (!upd_ack && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic apply(input logic [31:0] dw, input logic [7:0] sw, input logic [31:0] gw, input string req);
    int lat;
    @(negedge clk);
    div_word = dw; src_word = sw; gate_word = gw;
    request(lat);
    check(upd_ack === 1'b1, req, upd_ack, 1);
    @(negedge clk);
    check(upd_busy === 1'b0 && upd_ack === 1'b0, req, {upd_busy, upd_ack}, 0);
    repeat (600) @(posedge clk);
  endtask

  task automatic expect_all(input logic [31:0] dw, input logic [7:0] sw, input logic [31:0] gw, input string req);
    measure();
    for (int i = 0; i < NC; i++) begin
      int n, e;
      bit run;
      n = pick_div(dw, sw, i);
      run = gw[i] && !(gw[16+i] && cmd_idle[i] && dat_idle[i]);
      e = exp_edges(n, run);
      check(got[i] >= e - 1 && got[i] <= e + 1, req, got[i], e);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int lat, seed_dummy;
    logic [31:0] dw, gw, old_dw;
    logic [7:0] sw;
    seed_dummy = $urandom(32'h5eed_c10c);

    repeat (4) @(posedge clk);
    #1;
    // R9: reset state
    check(card_clk === 4'b0 && upd_busy === 1'b0 && upd_ack === 1'b0, "R9",
          {card_clk, upd_busy, upd_ack}, 0);
    @(negedge clk) rst_n = 1'b1;
    measure();
    for (int i = 0; i < NC; i++) check(got[i] == 0, "R9", got[i], 0);

    // R1 R2: distinct dividers, each slot picks a different one
    dw = {8'd3, 8'd60, 8'd5, 8'd1};
    sw = {2'd0, 2'd3, 2'd1, 2'd2};
    gw = 32'h0000_000F;
    apply(dw, sw, gw, "R1");
    expect_all(dw, sw, gw, "R1");
    check(got[1] >= 239 && got[1] <= 241, "R2", got[1], 240);

    // R3: zero divider passes the reference
    dw = {8'd0, 8'd2, 8'd0, 8'd7};
    sw = {2'd3, 2'd0, 2'd1, 2'd3};
    apply(dw, sw, gw, "R3");
    expect_all(dw, sw, gw, "R3");

    // R6: words changed without a request have no effect
    old_dw = dw;
    @(negedge clk);
    div_word = 32'h0909_0909; gate_word = 32'h0;
    repeat (50) @(posedge clk);
    expect_all(old_dw, sw, gw, "R6");

    // R4: disable slots 1 and 2, including a bypass slot
    gw = 32'h0000_0009;
    apply(dw, sw, gw, "R4");
    expect_all(dw, sw, gw, "R4");
    check(got[2] == 0 && got[1] == 0, "R4", got[1] + got[2], 0);

    // R5: low power, one idle, both idle, neither idle
    dw = {8'd0, 8'd0, 8'd4, 8'd4};
    sw = 8'h00;
    gw = 32'h000F_000F;
    @(negedge clk);
    cmd_idle = 4'b1111; dat_idle = 4'b0000;
    apply(dw, sw, gw, "R5");
    expect_all(dw, sw, gw, "R5");
    @(negedge clk);
    dat_idle = 4'b1111;
    repeat (20) @(posedge clk);
    expect_all(dw, sw, gw, "R5");
    check(got[0] == 0, "R5", got[0], 0);
    sw = 8'hFF;
    apply(dw, sw, gw, "R5");
    expect_all(dw, sw, gw, "R5");
    @(negedge clk);
    cmd_idle = 4'b0101; dat_idle = 4'b0000;
    repeat (20) @(posedge clk);
    expect_all(dw, sw, gw, "R5");
    check(got[3] >= W - 1, "R5", got[3], W);
    @(negedge clk);
    cmd_idle = 4'b0; dat_idle = 4'b0;

    // R8 R7: start update during a long high phase, re-request while busy
    dw = {8'd1, 8'd1, 8'd1, 8'd250};
    sw = 8'h00; gw = 32'h0000_000F;
    apply(dw, sw, gw, "R8");
    @(posedge card_clk[0]);
    @(negedge clk);
    div_word = {8'd1, 8'd1, 8'd1, 8'd12};
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    repeat (20) @(negedge clk);
    check(upd_busy === 1'b1, "R8", upd_busy, 1);
    div_word = {8'd1, 8'd1, 8'd1, 8'd2};
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    lat = 0;
    while (!upd_ack && lat < 2000) begin @(negedge clk); lat++; end
    check(lat > 150 && lat < 260, "R8", lat, 230);
    repeat (40) @(posedge clk);
    expect_all({8'd1, 8'd1, 8'd1, 8'd12}, sw, gw, "R7");

    // R1 R2 R3 R4: constrained random configurations
    for (int it = 0; it < 8; it++) begin
      for (int k = 0; k < 4; k++) dw[8*k +: 8] = ($urandom % 4 == 0) ? 8'd0 : 8'(1 + $urandom % 20);
      sw = 8'($urandom);
      gw = {16'h0, 12'h0, 4'($urandom)};
      apply(dw, sw, gw, "R1");
      expect_all(dw, sw, gw, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule